// File: doc/BRIEF.md
# Four-Channel DAC Register Core with Nonvolatile Shadows

This block is the digital state holder behind a four-channel, 8-bit voltage DAC. Each channel has a working code register, and one working control byte holds a mute bit and a shutdown bit for every channel. Every working register has a nonvolatile shadow copy. Decoded commands from a serial front end write a working register, recall a shadow into its working register, store a working register into its shadow, or read a shadow back out.

The core turns the working registers into one 8-bit code and one 2-bit output mode per channel. The modes are normal, muted (the output is driven to the channel's low reference) and high impedance. The shadow store is modelled as a register array. A busy window of programmable length follows every store. When reset is released, the working registers reload from their shadows. An asynchronous hard-mute pin mutes every channel without changing any register.

Top module: `dac_nvreg_core`

## Requirements
- R1: While rst_n is low, every chan_code is 0, every chan_mode is 00, and nv_busy, rd_valid and low_power are 0. The shadow registers are not affected by reset.
- R2: A command with cmd_valid high and cmd_op = 1 (write) loads cmd_data into the addressed working register. The new value is visible from the next cycle. Other registers are unchanged.
- R3: On the first clock edge after rst_n rises, every working register, including the control byte, takes its shadow's value. Any command presented in that cycle is ignored.
- R4: cmd_op = 3 (store) copies a working register into its shadow. cmd_op = 2 (recall) copies a shadow into its working register. cmd_op = 4 (read) makes rd_valid high for exactly the next cycle, with rd_data equal to the addressed shadow.
- R5: cmd_ctrl_sel = 1 addresses the control byte, and cmd_chan is then ignored. In that byte, bit 4+i is the mute bit of channel i and bit i is its shutdown bit.
- R6: chan_mode[2i+1:2i] encodes channel i as 00 normal, 01 mute or 10 high impedance. When both the shutdown and mute bits of a channel are set, shutdown wins.
- R7: The code register of a channel is cleared on the edge where that channel's shutdown bit becomes set, and it reads 0 as long as the bit stays set. Writes and recalls to it are discarded during that time.
- R8: low_power is high exactly when all four shutdown bits are set.
- R9: While hard_mute is high, every chan_mode is 01, with no clock needed. No register changes, so the previous modes return when hard_mute falls.
- R10: An accepted store raises nv_busy for NV_WR_CYC cycles, starting the next cycle. While nv_busy is high, store, recall and read commands are ignored, and writes are still accepted.
- R11: Opcodes other than 1 to 4 have no effect, and neither does any command while cmd_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | Single-cycle command strobe |
| cmd_op | input | 4 | Opcode: 1 write, 2 recall, 3 store, 4 read |
| cmd_ctrl_sel | input | 1 | 1 selects the control byte instead of a channel |
| cmd_chan | input | 2 | Channel index |
| cmd_data | input | 8 | Write data |
| hard_mute | input | 1 | Asynchronous global mute, active high |
| chan_code | output | 32 | Working codes, channel i at bits [8i+7:8i] |
| chan_mode | output | 8 | Output modes, channel i at bits [2i+1:2i] |
| low_power | output | 1 | All channels shut down |
| nv_busy | output | 1 | Shadow store in progress |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Shadow read data |

## Verification
A reference model compares every output each cycle while directed sequences drive the block. Plain writes and recalls with distinct per-channel values expose crossed channel indices and show whether a recall took the shadow or the live value. Control bytes that set mute alone, mute together with shutdown, and all four shutdowns separate the priority rule, the clearing of codes and the low-power flag. Commands issued while busy, in the restore cycle and with illegal opcodes must leave the outputs untouched. A reset in the middle of the run, preceded by stores, shows that the shadows survive and are restored.

// File: rtl/dac_nvreg_pkg.sv
`timescale 1ns/1ps
package dac_nvreg_pkg;
  localparam int NCH = 4;              // channels
  localparam int DW  = 8;              // code width
  localparam int CW  = 2 * NCH;        // control byte: mute high half, shutdown low half
  localparam int CHW = $clog2(NCH);    // channel index width
  localparam int OPW = 4;              // opcode width
  localparam int MW  = 2;              // per-channel mode width

  typedef enum logic [OPW-1:0] {
    OP_NOP    = 4'd0,
    OP_WRITE  = 4'd1,
    OP_RECALL = 4'd2,
    OP_STORE  = 4'd3,
    OP_READ   = 4'd4
  } op_e;

  typedef enum logic [MW-1:0] {
    MODE_NORMAL = 2'b00,
    MODE_MUTE   = 2'b01,
    MODE_HIZ    = 2'b10
  } mode_e;
endpackage

// File: rtl/dac_nvreg_cmd.sv
`timescale 1ns/1ps
module dac_nvreg_cmd
  import dac_nvreg_pkg::*;
(
  input  logic           cmd_valid,
  input  logic [OPW-1:0] cmd_op,
  input  logic           cmd_ctrl_sel,
  input  logic [CHW-1:0] cmd_chan,
  input  logic           nv_busy,
  input  logic           restoring,
  output logic [NCH-1:0] wr_code,
  output logic [NCH-1:0] rc_code,
  output logic [NCH-1:0] st_code,
  output logic           wr_ctrl,
  output logic           rc_ctrl,
  output logic           st_ctrl,
  output logic           rd_req
);
  logic           go;
  logic           nv_ok;
  logic           is_wr, is_rc, is_st, is_rd;
  logic [NCH-1:0] chan_hit;

  always_comb begin
    go    = cmd_valid && !restoring;
    nv_ok = go && !nv_busy;
    is_wr = go    && (cmd_op == OP_WRITE);
    is_rc = nv_ok && (cmd_op == OP_RECALL);
    is_st = nv_ok && (cmd_op == OP_STORE);
    is_rd = nv_ok && (cmd_op == OP_READ);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_hit
    assign chan_hit[i] = !cmd_ctrl_sel && (cmd_chan == CHW'(i));
  end

  always_comb begin
    wr_code = {NCH{is_wr}} & chan_hit;
    rc_code = {NCH{is_rc}} & chan_hit;
    st_code = {NCH{is_st}} & chan_hit;
    wr_ctrl = is_wr && cmd_ctrl_sel;
    rc_ctrl = is_rc && cmd_ctrl_sel;
    st_ctrl = is_st && cmd_ctrl_sel;
    rd_req  = is_rd;
  end
endmodule

// File: rtl/dac_nvreg_nvstore.sv
`timescale 1ns/1ps
module dac_nvreg_nvstore
  import dac_nvreg_pkg::*;
#(
  parameter int NV_WR_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    st_code,
  input  logic              st_ctrl,
  input  logic [NCH*DW-1:0] work_code,
  input  logic [CW-1:0]     work_ctrl,
  input  logic              rd_req,
  input  logic              rd_sel,
  input  logic [CHW-1:0]    rd_chan,
  output logic [NCH*DW-1:0] nv_code,
  output logic [CW-1:0]     nv_ctrl,
  output logic              nv_busy,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data
);
  localparam int CNTW = $clog2(NV_WR_CYC + 1);

  logic [DW-1:0]   nv_q [NCH];
  logic [CW-1:0]   nvc_q;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            rdv_d;
  logic [DW-1:0]   rdd_q, rdd_d;
  logic            rdv_q;

  // shadow array: not reset, survives rst_n
  for (genvar i = 0; i < NCH; i++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (st_code[i]) nv_q[i] <= work_code[i*DW +: DW];
    end
    assign nv_code[i*DW +: DW] = nv_q[i];
  end

  always_ff @(posedge clk) begin
    if (st_ctrl) nvc_q <= work_ctrl;
  end
  assign nv_ctrl = nvc_q;

  // programming window counter
  always_comb begin
    if (|st_code || st_ctrl)  cnt_d = CNTW'(NV_WR_CYC);
    else if (cnt_q != '0)     cnt_d = cnt_q - CNTW'(1);
    else                      cnt_d = cnt_q;
  end

  always_comb begin
    rdv_d = rd_req;
    rdd_d = rdd_q;
    if (rd_req) rdd_d = rd_sel ? DW'(nvc_q) : nv_q[rd_chan];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdv_q <= 1'b0;
      rdd_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rdv_q <= rdv_d;
      rdd_q <= rdd_d;
    end
  end

  assign nv_busy  = (cnt_q != '0);
  assign rd_valid = rdv_q;
  assign rd_data  = rdd_q;
endmodule

// File: rtl/dac_nvreg_work.sv
`timescale 1ns/1ps
module dac_nvreg_work
  import dac_nvreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    wr_code,
  input  logic [NCH-1:0]    rc_code,
  input  logic              wr_ctrl,
  input  logic              rc_ctrl,
  input  logic [DW-1:0]     data_in,
  input  logic [NCH*DW-1:0] nv_code,
  input  logic [CW-1:0]     nv_ctrl,
  output logic [NCH*DW-1:0] code_q,
  output logic [CW-1:0]     ctrl_q,
  output logic              restoring
);
  logic          rest_q;
  logic [CW-1:0] ctrl_d;

  always_comb begin
    if (rest_q)       ctrl_d = nv_ctrl;
    else if (wr_ctrl) ctrl_d = data_in[CW-1:0];
    else if (rc_ctrl) ctrl_d = nv_ctrl;
    else              ctrl_d = ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rest_q <= 1'b1;
      ctrl_q <= '0;
    end else begin
      rest_q <= 1'b0;
      ctrl_q <= ctrl_d;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_code
    logic [DW-1:0] cur, nxt;
    assign cur = code_q[i*DW +: DW];
    always_comb begin
      if (ctrl_d[i])       nxt = '0;   // shutdown clears the code
      else if (rest_q)     nxt = nv_code[i*DW +: DW];
      else if (wr_code[i]) nxt = data_in;
      else if (rc_code[i]) nxt = nv_code[i*DW +: DW];
      else                 nxt = cur;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q[i*DW +: DW] <= '0;
      else        code_q[i*DW +: DW] <= nxt;
    end
  end

  assign restoring = rest_q;
endmodule

// File: rtl/dac_nvreg_outmode.sv
`timescale 1ns/1ps
module dac_nvreg_outmode
  import dac_nvreg_pkg::*;
(
  input  logic [CW-1:0]     ctrl,
  input  logic              hard_mute,
  output logic [NCH*MW-1:0] mode,
  output logic              low_power
);
  for (genvar i = 0; i < NCH; i++) begin : g_mode
    mode_e m;
    always_comb begin
      if (hard_mute)         m = MODE_MUTE;
      else if (ctrl[i])      m = MODE_HIZ;
      else if (ctrl[NCH+i])  m = MODE_MUTE;
      else                   m = MODE_NORMAL;
    end
    assign mode[i*MW +: MW] = m;
  end

  assign low_power = &ctrl[NCH-1:0];
endmodule

// File: rtl/dac_nvreg_core.sv
`timescale 1ns/1ps
module dac_nvreg_core
  import dac_nvreg_pkg::*;
#(
  parameter int NV_WR_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [OPW-1:0]    cmd_op,
  input  logic              cmd_ctrl_sel,
  input  logic [CHW-1:0]    cmd_chan,
  input  logic [DW-1:0]     cmd_data,
  input  logic              hard_mute,
  output logic [NCH*DW-1:0] chan_code,
  output logic [NCH*MW-1:0] chan_mode,
  output logic              low_power,
  output logic              nv_busy,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data
);
  logic [NCH-1:0]    wr_code, rc_code, st_code;
  logic              wr_ctrl, rc_ctrl, st_ctrl, rd_req;
  logic              restoring;
  logic [NCH*DW-1:0] code_q, nv_code;
  logic [CW-1:0]     ctrl_q, nv_ctrl;

  dac_nvreg_cmd u_cmd (
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_ctrl_sel (cmd_ctrl_sel),
    .cmd_chan     (cmd_chan),
    .nv_busy      (nv_busy),
    .restoring    (restoring),
    .wr_code      (wr_code),
    .rc_code      (rc_code),
    .st_code      (st_code),
    .wr_ctrl      (wr_ctrl),
    .rc_ctrl      (rc_ctrl),
    .st_ctrl      (st_ctrl),
    .rd_req       (rd_req)
  );

  dac_nvreg_work u_work (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_code   (wr_code),
    .rc_code   (rc_code),
    .wr_ctrl   (wr_ctrl),
    .rc_ctrl   (rc_ctrl),
    .data_in   (cmd_data),
    .nv_code   (nv_code),
    .nv_ctrl   (nv_ctrl),
    .code_q    (code_q),
    .ctrl_q    (ctrl_q),
    .restoring (restoring)
  );

  dac_nvreg_nvstore #(.NV_WR_CYC(NV_WR_CYC)) u_nv (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_code   (st_code),
    .st_ctrl   (st_ctrl),
    .work_code (code_q),
    .work_ctrl (ctrl_q),
    .rd_req    (rd_req),
    .rd_sel    (cmd_ctrl_sel),
    .rd_chan   (cmd_chan),
    .nv_code   (nv_code),
    .nv_ctrl   (nv_ctrl),
    .nv_busy   (nv_busy),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  dac_nvreg_outmode u_mode (
    .ctrl      (ctrl_q),
    .hard_mute (hard_mute),
    .mode      (chan_mode),
    .low_power (low_power)
  );

  assign chan_code = code_q;
endmodule

// File: rtl/dac_nvreg_chk.sv
`timescale 1ns/1ps
module dac_nvreg_chk
  import dac_nvreg_pkg::*;
#(
  parameter int NV_WR_CYC = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [OPW-1:0]    cmd_op,
  input logic              hard_mute,
  input logic [NCH*DW-1:0] chan_code,
  input logic [NCH*MW-1:0] chan_mode,
  input logic              low_power,
  input logic              nv_busy,
  input logic              rd_valid
);
  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (nv_busy) run_q <= run_q + 32'd1;
    else              run_q <= '0;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assert_mode_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      chan_mode[i*MW +: MW] != 2'b11);
    assert_hiz_zero_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!hard_mute && chan_mode[i*MW +: MW] == 2'b10) |-> chan_code[i*DW +: DW] == '0);
    assert_hard_mute_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hard_mute |-> chan_mode[i*MW +: MW] == 2'b01);
    assert_low_power_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (low_power && !hard_mute) |-> chan_mode[i*MW +: MW] == 2'b10);
  end

  assert_busy_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nv_busy) |-> $past(cmd_valid && cmd_op == 4'(OP_STORE)));
  assert_busy_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |-> run_q < NV_WR_CYC);
  assert_busy_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nv_busy) |-> run_q == NV_WR_CYC);
  assert_read_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid && cmd_op == 4'(OP_READ) && !nv_busy));
endmodule

bind dac_nvreg_core dac_nvreg_chk #(.NV_WR_CYC(NV_WR_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .hard_mute (hard_mute),
  .chan_code (chan_code),
  .chan_mode (chan_mode),
  .low_power (low_power),
  .nv_busy   (nv_busy),
  .rd_valid  (rd_valid)
);

// File: tb/dac_nvreg_core_tb.sv
`timescale 1ns/1ps
module dac_nvreg_core_tb;
  localparam int N = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = 4'd0;
  logic        cmd_ctrl_sel = 1'b0;
  logic [1:0]  cmd_chan = 2'd0;
  logic [7:0]  cmd_data = 8'd0;
  logic        hard_mute = 1'b0;
  logic [31:0] chan_code;
  logic [7:0]  chan_mode;
  logic        low_power, nv_busy, rd_valid;
  logic [7:0]  rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;   // 50 MHz

  dac_nvreg_core #(.NV_WR_CYC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ctrl_sel(cmd_ctrl_sel), .cmd_chan(cmd_chan), .cmd_data(cmd_data),
    .hard_mute(hard_mute), .chan_code(chan_code), .chan_mode(chan_mode),
    .low_power(low_power), .nv_busy(nv_busy), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // ---------------- reference model ----------------
  logic [7:0] m_code [4];
  logic [7:0] m_ctrl;
  logic [7:0] m_nv   [4] = '{default: 'x};
  logic [7:0] m_nvc  = 'x;
  int         m_cnt;
  bit         m_rest;
  bit         m_rdv;
  logic [7:0] m_rdd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_code[i] = 8'h00;
      m_ctrl = 8'h00; m_rest = 1'b1; m_cnt = 0; m_rdv = 1'b0; m_rdd = 8'h00;
    end else begin
      bit busy_now;
      busy_now = (m_cnt != 0);
      m_rdv = 1'b0;
      if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (m_rest) begin
        for (int i = 0; i < 4; i++) m_code[i] = m_nv[i];
        m_ctrl = m_nvc;
        m_rest = 1'b0;
      end else if (cmd_valid) begin
        if (cmd_op == 4'd1) begin
          if (cmd_ctrl_sel) m_ctrl = cmd_data; else m_code[cmd_chan] = cmd_data;
        end else if (!busy_now && cmd_op == 4'd2) begin
          if (cmd_ctrl_sel) m_ctrl = m_nvc; else m_code[cmd_chan] = m_nv[cmd_chan];
        end else if (!busy_now && cmd_op == 4'd3) begin
          if (cmd_ctrl_sel) m_nvc = m_ctrl; else m_nv[cmd_chan] = m_code[cmd_chan];
          m_cnt = N;
        end else if (!busy_now && cmd_op == 4'd4) begin
          m_rdv = 1'b1;
          m_rdd = cmd_ctrl_sel ? m_nvc : m_nv[cmd_chan];
        end
      end
      for (int i = 0; i < 4; i++) begin
        if (m_ctrl[i] === 1'b1)      m_code[i] = 8'h00;
        else if (m_ctrl[i] !== 1'b0) m_code[i] = 'x;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_mode(input int i);
    if (hard_mute) return 2'b01;
    if ($isunknown({m_ctrl[4+i], m_ctrl[i]})) return 2'bxx;
    if (m_ctrl[i]) return 2'b10;
    if (m_ctrl[4+i]) return 2'b01;
    return 2'b00;
  endfunction

  // per-cycle comparison, away from the active edge
  always begin
    @(negedge clk); #2;
    for (int i = 0; i < 4; i++) begin
      logic [1:0] em;
      em = exp_mode(i);
      if (!$isunknown(m_code[i])) chk("R2 code", 32'(chan_code[i*8 +: 8]), 32'(m_code[i]));
      if (!$isunknown(em))        chk("R6 mode", 32'(chan_mode[i*2 +: 2]), 32'(em));
    end
    if (!$isunknown(m_ctrl[3:0])) chk("R8 low_power", 32'(low_power), 32'(&m_ctrl[3:0]));
    chk("R10 busy", 32'(nv_busy), 32'(m_cnt != 0));
    chk("R4 rd_valid", 32'(rd_valid), 32'(m_rdv));
    if (m_rdv && !$isunknown(m_rdd)) chk("R4 rd_data", 32'(rd_data), 32'(m_rdd));
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [3:0] op, input logic sel, input logic [1:0] ch, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_ctrl_sel = sel; cmd_chan = ch; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 4'd0;
  endtask

  task automatic wait_idle();
    while (nv_busy) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 code", chan_code, 32'h0);
    chk("R1 mode", 32'(chan_mode), 32'h0);
    chk("R1 busy/rd/lp", 32'({nv_busy, rd_valid, low_power}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // program working and shadow registers
    send(4'd1, 1'b1, 2'd0, 8'h00);
    send(4'd1, 1'b0, 2'd0, 8'h11);
    send(4'd1, 1'b0, 2'd1, 8'h22);
    send(4'd1, 1'b0, 2'd2, 8'h33);
    send(4'd1, 1'b0, 2'd3, 8'h44);
    chk("R2 write ch2", 32'(chan_code[23:16]), 32'h33);
    for (int c = 0; c < 4; c++) begin
      send(4'd3, 1'b0, 2'(c), 8'h00);
      wait_idle();
    end
    send(4'd3, 1'b1, 2'd0, 8'h00);
    wait_idle();

    // R4 read and recall
    send(4'd4, 1'b0, 2'd2, 8'h00);
    chk("R4 read pulse", 32'({rd_valid, rd_data}), 32'h133);
    send(4'd1, 1'b0, 2'd1, 8'hAA);
    send(4'd2, 1'b0, 2'd1, 8'h00);
    chk("R4 recall ch1", 32'(chan_code[15:8]), 32'h22);

    // R5 control layout, R6 priority, R7 clear
    send(4'd1, 1'b1, 2'd3, 8'h20);
    chk("R5 ch1 mute", 32'(chan_mode), 32'h04);
    send(4'd1, 1'b1, 2'd0, 8'h22);
    chk("R6 shutdown wins", 32'(chan_mode[3:2]), 32'h2);
    chk("R7 cleared", 32'(chan_code[15:8]), 32'h0);
    send(4'd1, 1'b0, 2'd1, 8'h77);
    chk("R7 write discarded", 32'(chan_code[15:8]), 32'h0);

    // R8 all shut down
    send(4'd1, 1'b1, 2'd0, 8'h0F);
    chk("R8 low_power set", 32'({low_power, chan_code}), {1'b1, 32'h0});
    send(4'd1, 1'b1, 2'd0, 8'h00);
    chk("R8 low_power clear", 32'(low_power), 32'h0);

    // R9 hard mute
    send(4'd1, 1'b0, 2'd0, 8'h10);
    send(4'd1, 1'b0, 2'd1, 8'h20);
    send(4'd1, 1'b0, 2'd2, 8'h30);
    send(4'd1, 1'b0, 2'd3, 8'h40);
    @(negedge clk); hard_mute = 1'b1; #2;
    chk("R9 all muted", 32'(chan_mode), 32'h55);
    send(4'd1, 1'b0, 2'd3, 8'h99);
    @(negedge clk); hard_mute = 1'b0; #2;
    chk("R9 modes return", 32'(chan_mode), 32'h00);
    chk("R9 registers kept", chan_code, 32'h99302010);

    // R10 busy window
    send(4'd3, 1'b0, 2'd0, 8'h00);
    chk("R10 busy high", 32'(nv_busy), 32'h1);
    send(4'd2, 1'b0, 2'd3, 8'h00);
    chk("R10 recall ignored", 32'(chan_code[31:24]), 32'h99);
    send(4'd1, 1'b0, 2'd2, 8'h5A);
    chk("R10 write while busy", 32'(chan_code[23:16]), 32'h5A);
    wait_idle();

    // R11 illegal opcode and idle strobe
    send(4'hF, 1'b0, 2'd1, 8'hC3);
    chk("R11 bad opcode", chan_code, 32'h995A2010);
    @(negedge clk);
    cmd_op = 4'd1; cmd_chan = 2'd1; cmd_data = 8'hC3;
    @(negedge clk); cmd_op = 4'd0;
    chk("R11 no valid", chan_code, 32'h995A2010);

    // R3 restore after reset, shadows retained
    send(4'd1, 1'b1, 2'd0, 8'h40);
    send(4'd3, 1'b1, 2'd0, 8'h00);
    wait_idle();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); #2;
    chk("R1 reset again", chan_code, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    cmd_valid = 1'b1; cmd_op = 4'd1; cmd_ctrl_sel = 1'b0; cmd_chan = 2'd0; cmd_data = 8'hEE;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 4'd0;
    chk("R3 restored codes", chan_code, 32'h44332210);
    chk("R3 restored ctrl", 32'(chan_mode), 32'h10);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule